// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns one parallel character into a frame on a single serial line that rests high. A frame has a low start bit, then seven or eight data bits with the least significant bit first, then an optional parity bit, then a high stop bit. Each character carries its own start and stop bits, so a receiver can resynchronise on every character.

Characters arrive through a valid/ready handshake. The data length, the parity enable, the parity sense and the bit-time divisor are all captured at the moment a character is accepted. Changing them while a frame is on the line does not affect that frame. A `busy` flag is high for the whole frame. The handshake reopens in the last clock of the stop bit, so a waiting character can follow with no idle gap.

Each bit lasts `div_val + 1` system clocks. An internal counter produces this timing.

Top module: `async_frame_tx`

## Requirements
- R1: While `rst` is high at a rising clock edge (synchronous, active high), the block returns to idle. In idle, `tx_line` is 1, `busy` is 0 and `in_ready` is 1. The line stays at 1 whenever no frame is in progress.
- R2: A character is accepted at a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `tx_line` is 0 for the start bit and `busy` is 1.
- R3: Every bit of a frame is held on `tx_line` for exactly `div_val + 1` clock cycles. The value of `div_val` used is the one sampled at acceptance.
- R4: Data bits follow the start bit, least significant bit first. With `cfg_len8` = 1, bits 0 to 7 are sent. With `cfg_len8` = 0, bits 0 to 6 are sent and bit 7 has no effect.
- R5: With `cfg_par_en` = 1, one parity bit follows the last data bit. With `cfg_par_odd` = 0 (even parity) it is the XOR of the data bits sent. With `cfg_par_odd` = 1 (odd parity) it is the inverse of that XOR. For example, 0x41 with 8 bits and even parity gives 0.
- R6: With `cfg_par_en` = 0, the stop bit directly follows the last data bit. The frame is then 9 bits (7 data) or 10 bits (8 data) long. With parity it is 10 or 11 bits.
- R7: The stop bit is 1. If no new character is accepted in its last cycle, `busy` falls after it and `tx_line` stays at 1.
- R8: `in_ready` is 0 throughout a frame except in the last clock cycle of the stop bit. While the frame runs, changes on `in_valid`, `in_data`, the configuration inputs and `div_val` do not alter the frame.
- R9: A character accepted in the last cycle of a stop bit starts its start bit in the very next cycle. `busy` stays 1 and no idle cycle appears between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Bit time minus one, in clock cycles |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven data bits |
| cfg_par_en | input | 1 | 1: insert a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character on `in_data` is offered |
| in_ready | output | 1 | Block can take a character this cycle |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is on the line |

## Verification
Take edge E0 as the rising edge where a character is accepted. Frame bit k then occupies the cycles following edges E0 + k·(D+1) through E0 + (k+1)·(D+1) − 1. The line is back at idle, or at the next start bit, after edge E0 + N·(D+1), where N is the frame length. The bench samples at every falling edge of the frame, with an index j counted from the first falling edge after E0. It checks `tx_line` against bit ⌊j/(D+1)⌋ of a frame built arithmetically from the data and configuration. It expects `in_ready` to be high only at j = N·(D+1) − 1 and checks the idle state at the next falling edge. It sweeps every data value under all eight length and parity combinations, and uses several divisors, mid-frame disturbances, chained frames and a mid-frame reset.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  localparam int UFTX_DATA_MAX = 8;
  localparam int UFTX_DATA_MIN = 7;
  localparam int UFTX_FRAME_MAX = UFTX_DATA_MAX + 3;
  localparam int UFTX_CNT_W = $clog2(UFTX_FRAME_MAX);

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
  } uftx_cfg_t;

  // Frame image, bit 0 leaves first; unused upper positions are idle ones.
  function automatic logic [UFTX_FRAME_MAX-1:0] uftx_build(
      input logic [UFTX_DATA_MAX-1:0] d, input uftx_cfg_t c, input logic p);
    logic [UFTX_FRAME_MAX-1:0] f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < UFTX_DATA_MAX; i++) begin
      if (i < UFTX_DATA_MIN || c.len8) f[i+1] = d[i];
    end
    if (c.par_en) begin
      if (c.len8) f[UFTX_DATA_MAX+1] = p;
      else        f[UFTX_DATA_MIN+1] = p;
    end
    return f;
  endfunction

  function automatic logic [UFTX_CNT_W-1:0] uftx_bits(input uftx_cfg_t c);
    int n;
    n = 2 + (c.len8 ? UFTX_DATA_MAX : UFTX_DATA_MIN) + (c.par_en ? 1 : 0);
    return UFTX_CNT_W'(n);
  endfunction

endpackage

// File: rtl/uftx_parity.sv
module uftx_parity
  import uftx_pkg::*;
(
  input  logic [UFTX_DATA_MAX-1:0] data,
  input  logic                     len8,
  input  logic                     odd,
  output logic                     par
);

  logic [UFTX_DATA_MAX-1:0] mask;

  generate
    for (genvar g = 0; g < UFTX_DATA_MAX; g++) begin : g_mask
      if (g < UFTX_DATA_MIN) begin : g_fixed
        assign mask[g] = 1'b1;
      end else begin : g_opt
        assign mask[g] = len8;
      end
    end
  endgenerate

  assign par = (^(data & mask)) ^ odd;

endmodule

// File: rtl/uftx_baud_gen.sv
module uftx_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;

  assign tick = run && (cnt_q == div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      div_q <= div_in;
    end else if (tick) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst) begin
      assert_cnt_range_R3: assert (cnt_q <= div_q)
        else $error("bit counter beyond latched divisor");
    end
  end

endmodule

// File: rtl/uftx_frame_ctrl.sv
module uftx_frame_ctrl
  import uftx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [UFTX_DATA_MAX-1:0] in_data,
  input  logic                     in_valid,
  input  uftx_cfg_t                cfg,
  input  logic                     par_bit,
  input  logic                     tick,
  output logic                     in_ready,
  output logic                     start,
  output logic                     tx_line,
  output logic                     busy
);

  logic [UFTX_FRAME_MAX-2:0] rest_q;
  logic [UFTX_CNT_W-1:0]     left_q;
  logic                      busy_q;
  logic                      tx_q;
  logic                      last_slot;
  logic [UFTX_FRAME_MAX-1:0] frame;

  assign last_slot = busy_q && (left_q == '0) && tick;
  assign in_ready  = !busy_q || last_slot;
  assign start     = in_valid && in_ready;
  assign frame     = uftx_build(in_data, cfg, par_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= 1'b1;
      busy_q <= 1'b0;
      left_q <= '0;
      rest_q <= '1;
    end else if (start) begin
      tx_q   <= frame[0];
      rest_q <= frame[UFTX_FRAME_MAX-1:1];
      left_q <= uftx_bits(cfg) - 1'b1;
      busy_q <= 1'b1;
    end else if (tick) begin
      if (left_q == '0) begin
        tx_q   <= 1'b1;
        busy_q <= 1'b0;
      end else begin
        tx_q   <= rest_q[0];
        rest_q <= {1'b1, rest_q[UFTX_FRAME_MAX-2:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign tx_line = tx_q;
  assign busy    = busy_q;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> tx_q);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!tx_q && busy_q));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick && !start) |=> $stable(tx_q));
  assert_stop_high_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> tx_q);
  assert_ready_gate_R8: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!busy_q || tick));

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import uftx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cfg_len8,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             tx_line,
  output logic             busy
);

  uftx_cfg_t cfg;
  logic      par_bit;
  logic      tick;
  logic      start;

  assign cfg.len8    = cfg_len8;
  assign cfg.par_en  = cfg_par_en;
  assign cfg.par_odd = cfg_par_odd;

  uftx_parity u_par (
    .data (in_data),
    .len8 (cfg_len8),
    .odd  (cfg_par_odd),
    .par  (par_bit)
  );

  uftx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .load   (start),
    .div_in (div_val),
    .run    (busy),
    .tick   (tick)
  );

  uftx_frame_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_data  (in_data),
    .in_valid (in_valid),
    .cfg      (cfg),
    .par_bit  (par_bit),
    .tick     (tick),
    .in_ready (in_ready),
    .start    (start),
    .tx_line  (tx_line),
    .busy     (busy)
  );

endmodule

// File: tb/async_frame_tx_tb.sv
module async_frame_tx_tb_top;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] div_val = '0;
  logic          cfg_len8 = 1'b1;
  logic          cfg_par_en = 1'b0;
  logic          cfg_par_odd = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          tx_line;
  logic          busy;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  async_frame_tx #(.DIV_W(DW)) dut_i (
    .clk(clk), .rst(rst), .div_val(div_val), .cfg_len8(cfg_len8),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .tx_line(tx_line), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_bit(input int k, input logic [7:0] d,
                                 input bit l8, input bit pe, input bit po);
    int len = l8 ? 8 : 7;
    int x = 0;
    if (k == 0) return 0;
    if (k <= len) return int'(d[k-1]);
    if (pe && k == len + 1) begin
      for (int i = 0; i < len; i++) x ^= int'(d[i]);
      return x ^ int'(po);
    end
    return 1;
  endfunction

  function automatic string bit_tag(input int k, input bit l8, input bit pe);
    int len = l8 ? 8 : 7;
    if (k == 0) return "R2 start bit";
    if (k <= len) return "R4 data bit";
    if (pe && k == len + 1) return "R5 parity bit";
    if (!pe && k == len + 1) return "R6 stop after data";
    return "R7 stop bit";
  endfunction

  // Called at a falling edge with the block idle (or at its last stop cycle when chained).
  task automatic run_frame(input logic [7:0] d, input bit l8, input bit pe,
                           input bit po, input int dv, input bit chain,
                           input bit poke);
    int n = 2 + (l8 ? 8 : 7) + (pe ? 1 : 0);
    int tot = n * (dv + 1);
    in_data = d; cfg_len8 = l8; cfg_par_en = pe; cfg_par_odd = po;
    div_val = DW'(dv); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int j = 0; j < tot; j++) begin
      int k = j / (dv + 1);
      chk(bit_tag(k, l8, pe), int'(tx_line), exp_bit(k, d, l8, pe, po));
      chk("R3 busy held over bit times", int'(busy), 1);
      chk((j == tot - 1) ? "R9 ready in last stop cycle" : "R8 ready low in frame",
          int'(in_ready), (j == tot - 1) ? 1 : 0);
      if (j == 0) begin
        in_valid = 1'b0;
        if (poke) begin
          in_valid = 1'b1; in_data = ~d; cfg_len8 = ~l8;
          cfg_par_en = ~pe; cfg_par_odd = ~po; div_val = DW'(dv + 1);
        end
      end
      if (poke && j == tot - 2) begin
        in_valid = 1'b0; in_data = d; cfg_len8 = l8;
        cfg_par_en = pe; cfg_par_odd = po; div_val = DW'(dv);
      end
      if (j == tot - 1 && chain) begin
        in_valid = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    if (!chain) begin
      chk("R7 line high after stop", int'(tx_line), 1);
      chk("R7 busy low after stop", int'(busy), 0);
      chk("R1 ready when idle", int'(in_ready), 1);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset tx_line", int'(tx_line), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset ready", int'(in_ready), 1);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 idle line stays high", int'(tx_line), 1);

    // R5 named case: 0x41, 8 bits, even parity gives parity 0
    run_frame(8'h41, 1'b1, 1'b1, 1'b0, 1, 1'b0, 1'b0);
    chk("R5 parity of 0x41 even", exp_bit(9, 8'h41, 1'b1, 1'b1, 1'b0), 0);

    // R4 R5 R6: all data values under every length/parity setting
    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 256; d++) begin
        run_frame(8'(d), c[0], c[1], c[2], 1, 1'b0, 1'b0);
      end
    end

    // R3: other divisors
    for (int dv = 0; dv < 6; dv++) begin
      run_frame(8'hA5, 1'b1, 1'b1, 1'b1, dv, 1'b0, 1'b0);
      run_frame(8'h3C, 1'b0, 1'b0, 1'b0, dv, 1'b0, 1'b0);
    end
    for (int d = 0; d < 256; d += 7) run_frame(8'(d), 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0);

    // R8: mid-frame disturbances ignored
    run_frame(8'h96, 1'b1, 1'b1, 1'b0, 2, 1'b0, 1'b1);
    run_frame(8'h7F, 1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b1);
    run_frame(8'h01, 1'b0, 1'b1, 1'b1, 3, 1'b0, 1'b1);

    // R9: chained frames with no idle gap
    run_frame(8'hC3, 1'b1, 1'b0, 1'b0, 1, 1'b1, 1'b0);
    run_frame(8'h5A, 1'b0, 1'b1, 1'b1, 1, 1'b1, 1'b0);
    run_frame(8'hFF, 1'b1, 1'b1, 1'b0, 2, 1'b0, 1'b0);

    // R1: reset in the middle of a frame
    in_data = 8'h00; cfg_len8 = 1'b1; cfg_par_en = 1'b0; div_val = DW'(3);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 line low mid start/data", int'(tx_line), 0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-frame reset line", int'(tx_line), 1);
    chk("R1 mid-frame reset busy", int'(busy), 0);
    chk("R1 mid-frame reset ready", int'(in_ready), 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run_frame(8'h55, 1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule